// File: doc/BRIEF.md
# Residue-Checked Add/Subtract Unit with Replay

This execution unit adds or subtracts two unsigned operands and holds each result back until a mod-3 residue check has confirmed it. The residue is predicted from the operands alone, apart from the adder. If the check fails, the unit runs the same operation again on the main adder. A pass on that second run marks the fault as transient, and the good result is then committed. A second failure asks an external power/clock manager to slow the clock or raise the supply, and the unit then makes one last attempt on a separately built alternate adder. If that attempt also fails, the unit reports an uncorrectable outcome and commits nothing.

Only one operation is in flight at a time. Two test-only inputs flip one chosen result bit. One of them sets how many main-adder evaluations of the operation are corrupted. The other sets whether the alternate-adder evaluation is corrupted. Together they reach every branch of the recovery path. Two saturating counters record transient recoveries and escalations.

Top module: `resadd_unit`

## Requirements
- R1: `op_ready` is high while the unit is idle and drops in the cycle after an operation is accepted (`op_valid` and `op_ready` both high at a clock edge). It stays low until the cycle that follows the `out_valid` cycle.
- R2: For an add (`op_sub`=0) the result is the WIDTH+1-bit value a+b, with the carry-out in the top bit. For a subtract (`op_sub`=1) the result is the WIDTH+1-bit value a + (2^WIDTH − b), so the top bit is set when a ≥ b.
- R3: An operation with no injected fault produces `out_valid` exactly 2 cycles after the acceptance edge, with `out_status`=2'b00 (clean) and the correct result. `chk_err` and `esc_req` stay low.
- R4: If only the first main evaluation is corrupted (`inj_main_cnt`=1), `chk_err` pulses once and the operation is re-executed. `out_valid` follows 4 cycles after acceptance with `out_status`=2'b01 (transient) and the correct result.
- R5: If both main evaluations are corrupted (`inj_main_cnt`=2, `inj_alt`=0), `chk_err` pulses twice and `esc_req` pulses for exactly one cycle. The alternate adder then delivers the correct result 6 cycles after acceptance with `out_status`=2'b10.
- R6: If the alternate evaluation is corrupted as well (`inj_alt`=1), `chk_err` pulses three times. `out_valid` comes 6 cycles after acceptance with `out_status`=2'b11 (uncorrectable) and `out_result` is all zeros.
- R7: `trans_cnt` increments by one for each status-2'b01 completion and holds at 255 once it gets there.
- R8: `esc_cnt` increments by one for each `esc_req` pulse and saturates at 255.
- R9: After reset, `op_ready`=1, `out_valid`=0, `esc_req`=0, `chk_err`=0 and both counters are 0.
- R10: The fault-inject inputs are sampled only at acceptance and affect only that operation. An operation that follows a faulted one completes clean, with status 2'b00 and latency 2.
- R11: Any single flipped bit, at any position 0..WIDTH of the result, is detected by the residue check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can accept an operation |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| inj_main_cnt | input | 2 | Test hook: number of main-adder evaluations to corrupt (0..2) |
| inj_alt | input | 1 | Test hook: corrupt the alternate-adder evaluation |
| inj_bit | input | IDXW | Test hook: result bit index to flip |
| out_valid | output | 1 | One-cycle completion pulse |
| out_status | output | 2 | 00 clean, 01 transient, 10 alternate path, 11 uncorrectable |
| out_result | output | WIDTH+1 | Committed result with carry in the top bit; zero when uncorrectable |
| chk_err | output | 1 | Residue mismatch seen in this check cycle |
| esc_req | output | 1 | One-cycle request to lower frequency or raise voltage |
| trans_cnt | output | CNT_W | Saturating count of transient recoveries |
| esc_cnt | output | CNT_W | Saturating count of escalations |

## Verification
A wrong internal state shows at the ports within a few cycles. A stuck or skipped sequencer state moves `out_valid` away from its fixed latency of 2, 4 or 6 cycles. It also changes the number of `chk_err` and `esc_req` pulses, and it can leave `op_ready` low. A mistracked attempt count shows at completion as a wrong `out_status` and as counters that drift from their expected totals. A fault-inject budget that leaks into the next operation turns that operation's clean completion into a replay.

// File: rtl/resadd_pkg.sv
package resadd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_CHECK, ST_REPLAY, ST_ALT, ST_COMMIT, ST_FAIL
  } seq_e;

  localparam logic [1:0] STS_CLEAN  = 2'b00;
  localparam logic [1:0] STS_TRANS  = 2'b01;
  localparam logic [1:0] STS_ALT    = 2'b10;
  localparam logic [1:0] STS_UNCORR = 2'b11;
endpackage

// File: rtl/resadd_mod3.sv
module resadd_mod3 #(
  parameter int N = 16
) (
  input  logic [N-1:0] v,
  output logic [1:0]   r
);
  logic [1:0] acc;
  logic [2:0] t;

  // Horner fold, MSB first: acc = (2*acc + bit) mod 3
  always_comb begin
    acc = 2'd0;
    t   = 3'd0;
    for (int i = N - 1; i >= 0; i--) begin
      t   = {acc, v[i]};
      acc = (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
    end
    r = acc;
  end
endmodule

// File: rtl/resadd_core.sv
module resadd_core #(
  parameter int WIDTH  = 16,
  parameter int IDXW   = 5,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic             flip_en,
  input  logic [IDXW-1:0]  flip_idx,
  output logic [WIDTH:0]   res
);
  logic [WIDTH-1:0] bx;
  logic [WIDTH:0]   raw;
  logic [WIDTH:0]   mask;

  assign bx = sub ? ~b : b;

  generate
    if (!RIPPLE) begin : g_fast
      assign raw = {1'b0, a} + {1'b0, bx} + {{WIDTH{1'b0}}, sub};
    end else begin : g_ripple
      logic [WIDTH:0] c;
      assign c[0] = sub;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign raw[i]   = a[i] ^ bx[i] ^ c[i];
        assign c[i+1]   = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
      end
      assign raw[WIDTH] = c[WIDTH];
    end
  endgenerate

  assign mask = flip_en ? ((WIDTH+1)'(1) << flip_idx) : '0;
  assign res  = raw ^ mask;
endmodule

// File: rtl/resadd_resck.sv
module resadd_resck #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  input  logic [WIDTH:0]   res,
  output logic             mismatch
);
  // residue of 2^WIDTH, added back for the subtract form a + (2^W - b)
  localparam logic [1:0] WRAP = (WIDTH % 2 == 0) ? 2'd1 : 2'd2;

  logic [1:0] ra, rb, rr, pred;
  logic [3:0] tot;

  resadd_mod3 #(.N(WIDTH))   u_ma (.v(a),   .r(ra));
  resadd_mod3 #(.N(WIDTH))   u_mb (.v(b),   .r(rb));
  resadd_mod3 #(.N(WIDTH+1)) u_mr (.v(res), .r(rr));

  always_comb begin
    if (sub) tot = {2'b00, ra} + (4'd3 - {2'b00, rb}) + {2'b00, WRAP};
    else     tot = {2'b00, ra} + {2'b00, rb};
    pred     = 2'(tot % 4'd3);
    mismatch = (pred != rr);
  end
endmodule

// File: rtl/resadd_ctrl.sv
module resadd_ctrl
  import resadd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [1:0]       inj_main_cnt,
  input  logic             inj_alt,
  input  logic             mismatch,
  output logic             accept,
  output logic             res_load,
  output logic             sel_alt,
  output logic             flip_en,
  output logic             commit,
  output logic             out_valid,
  output logic [1:0]       out_status,
  output logic             chk_err,
  output logic             esc_req,
  output logic [CNT_W-1:0] trans_cnt,
  output logic [CNT_W-1:0] esc_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  seq_e       state_q, state_d;
  logic [1:0] pass_q, pass_d;
  logic [1:0] injm_q, injm_d;
  logic       inja_q, inja_d;
  logic       trans_inc, esc_inc;

  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    injm_d  = injm_q;
    inja_d  = inja_q;
    unique case (state_q)
      ST_IDLE: if (op_valid) begin
        state_d = ST_EXEC;
        pass_d  = 2'd0;
        injm_d  = inj_main_cnt;
        inja_d  = inj_alt;
      end
      ST_EXEC, ST_REPLAY: begin
        state_d = ST_CHECK;
        if (injm_q != 2'd0) injm_d = injm_q - 2'd1;
      end
      ST_ALT: begin
        state_d = ST_CHECK;
        inja_d  = 1'b0;
      end
      ST_CHECK: begin
        if (!mismatch)            state_d = ST_COMMIT;
        else if (pass_q == 2'd0)  state_d = ST_REPLAY;
        else if (pass_q == 2'd1)  state_d = ST_ALT;
        else                      state_d = ST_FAIL;
        if (mismatch) pass_d = pass_q + 2'd1;
      end
      ST_COMMIT, ST_FAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign op_ready  = (state_q == ST_IDLE);
  assign accept    = op_ready & op_valid;
  assign res_load  = (state_q == ST_EXEC) | (state_q == ST_REPLAY) | (state_q == ST_ALT);
  assign sel_alt   = (state_q == ST_ALT);
  assign flip_en   = sel_alt ? inja_q : (injm_q != 2'd0);
  assign commit    = (state_q == ST_COMMIT);
  assign out_valid = commit | (state_q == ST_FAIL);
  assign chk_err   = (state_q == ST_CHECK) & mismatch;
  assign esc_req   = sel_alt;

  always_comb begin
    if (state_q == ST_FAIL)   out_status = STS_UNCORR;
    else if (pass_q == 2'd1)  out_status = STS_TRANS;
    else if (pass_q == 2'd2)  out_status = STS_ALT;
    else                      out_status = STS_CLEAN;
  end

  assign trans_inc = commit && (pass_q == 2'd1) && (trans_cnt != CNT_MAX);
  assign esc_inc   = sel_alt && (esc_cnt != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pass_q    <= 2'd0;
      injm_q    <= 2'd0;
      inja_q    <= 1'b0;
      trans_cnt <= '0;
      esc_cnt   <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      injm_q  <= injm_d;
      inja_q  <= inja_d;
      if (trans_inc) trans_cnt <= trans_cnt + 1'b1;
      if (esc_inc)   esc_cnt   <= esc_cnt + 1'b1;
    end
  end

  // R1
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> op_ready);
  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !op_ready);
  // R3
  clean_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && !mismatch && pass_q == 2'd0) |=> (out_valid && out_status == STS_CLEAN));
  // R5
  esc_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_req |-> $past(chk_err));
  // R5
  esc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_req |=> !esc_req);
  // R7
  trans_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trans_cnt) == CNT_MAX) |-> (trans_cnt == CNT_MAX));
  // R8
  esc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_cnt >= $past(esc_cnt)));
endmodule

// File: rtl/resadd_unit.sv
module resadd_unit
  import resadd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8,
  parameter int IDXW  = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       inj_main_cnt,
  input  logic             inj_alt,
  input  logic [IDXW-1:0]  inj_bit,
  output logic             out_valid,
  output logic [1:0]       out_status,
  output logic [WIDTH:0]   out_result,
  output logic             chk_err,
  output logic             esc_req,
  output logic [CNT_W-1:0] trans_cnt,
  output logic [CNT_W-1:0] esc_cnt
);
  logic [WIDTH-1:0] a_q, b_q;
  logic             sub_q;
  logic [IDXW-1:0]  bit_q;
  logic [WIDTH:0]   res_q, main_res, alt_res;
  logic             accept, res_load, sel_alt, flip_en, commit, mismatch;

  resadd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .inj_main_cnt(inj_main_cnt), .inj_alt(inj_alt), .mismatch(mismatch),
    .accept(accept), .res_load(res_load), .sel_alt(sel_alt), .flip_en(flip_en),
    .commit(commit), .out_valid(out_valid), .out_status(out_status),
    .chk_err(chk_err), .esc_req(esc_req), .trans_cnt(trans_cnt), .esc_cnt(esc_cnt)
  );

  resadd_core #(.WIDTH(WIDTH), .IDXW(IDXW), .RIPPLE(1'b0)) u_main (
    .a(a_q), .b(b_q), .sub(sub_q), .flip_en(flip_en & ~sel_alt),
    .flip_idx(bit_q), .res(main_res)
  );

  resadd_core #(.WIDTH(WIDTH), .IDXW(IDXW), .RIPPLE(1'b1)) u_alt (
    .a(a_q), .b(b_q), .sub(sub_q), .flip_en(flip_en & sel_alt),
    .flip_idx(bit_q), .res(alt_res)
  );

  resadd_resck #(.WIDTH(WIDTH)) u_chk (
    .a(a_q), .b(b_q), .sub(sub_q), .res(res_q), .mismatch(mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      sub_q <= 1'b0;
      bit_q <= '0;
      res_q <= '0;
    end else begin
      if (accept) begin
        a_q   <= op_a;
        b_q   <= op_b;
        sub_q <= op_sub;
        bit_q <= inj_bit;
      end
      if (res_load) res_q <= sel_alt ? alt_res : main_res;
    end
  end

  assign out_result = commit ? res_q : '0;

  // R6
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == STS_UNCORR) |-> (out_result == '0));
  // R11
  commit_clean_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status != STS_UNCORR) |-> $past(!mismatch));
endmodule

// File: tb/sim_resadd_unit.sv
module sim_resadd_unit;
  localparam int W    = 4;
  localparam int IDXW = $clog2(W + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           op_valid, op_ready, op_sub;
  logic [W-1:0]   op_a, op_b;
  logic [1:0]     inj_main_cnt;
  logic           inj_alt;
  logic [IDXW-1:0] inj_bit;
  logic           out_valid, chk_err, esc_req;
  logic [1:0]     out_status;
  logic [W:0]     out_result;
  logic [7:0]     trans_cnt, esc_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_trans = 0;
  int exp_esc   = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  resadd_unit #(.WIDTH(W), .CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sub(op_sub), .op_a(op_a), .op_b(op_b), .inj_main_cnt(inj_main_cnt),
    .inj_alt(inj_alt), .inj_bit(inj_bit), .out_valid(out_valid),
    .out_status(out_status), .out_result(out_result), .chk_err(chk_err),
    .esc_req(esc_req), .trans_cnt(trans_cnt), .esc_cnt(esc_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input bit sub,
                        input int injm, input bit inja, input int bitx, input string req);
    int exp_res, exp_sts, exp_lat, exp_errs, exp_escs;
    int lat, errs, escs;
    bit got;
    exp_res = sub ? (a + (1 << W) - b) : (a + b);
    if (injm == 0)       begin exp_sts = 0; exp_lat = 2; exp_errs = 0; exp_escs = 0; end
    else if (injm == 1)  begin exp_sts = 1; exp_lat = 4; exp_errs = 1; exp_escs = 0; end
    else if (!inja)      begin exp_sts = 2; exp_lat = 6; exp_errs = 2; exp_escs = 1; end
    else                 begin exp_sts = 3; exp_lat = 6; exp_errs = 3; exp_escs = 1; exp_res = 0; end
    @(negedge clk);
    chk(op_ready == 1'b1, "R1 ready idle", int'(op_ready), 1);
    op_valid = 1'b1; op_a = W'(a); op_b = W'(b); op_sub = sub;
    inj_main_cnt = 2'(injm); inj_alt = inja; inj_bit = IDXW'(bitx);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; inj_main_cnt = 2'd0; inj_alt = 1'b0;
    chk(op_ready == 1'b0, "R1 busy", int'(op_ready), 0);
    lat = 0; errs = 0; escs = 0; got = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (out_valid) begin got = 1'b1; break; end
      errs += int'(chk_err);
      escs += int'(esc_req);
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk(got, {req, " completion"}, int'(got), 1);
    chk(int'(out_result) == exp_res, {req, " result (R2)"}, int'(out_result), exp_res);
    chk(int'(out_status) == exp_sts, {req, " status"}, int'(out_status), exp_sts);
    chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    chk(errs == exp_errs, {req, " chk_err pulses (R11)"}, errs, exp_errs);
    chk(escs == exp_escs, {req, " esc_req pulses"}, escs, exp_escs);
    if (exp_sts == 1 && exp_trans < 255) exp_trans++;
    if (exp_escs == 1 && exp_esc < 255) exp_esc++;
    @(posedge clk);
    @(negedge clk);
    chk(op_ready == 1'b1, "R1 ready back", int'(op_ready), 1);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sub = 1'b0; op_a = '0; op_b = '0;
    inj_main_cnt = 2'd0; inj_alt = 1'b0; inj_bit = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(op_ready == 1'b1, "R9 ready", int'(op_ready), 1);
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    chk(chk_err == 1'b0 && esc_req == 1'b0, "R9 flags", int'(chk_err | esc_req), 0);
    chk(trans_cnt == 8'd0 && esc_cnt == 8'd0, "R9 counters", int'(trans_cnt) + int'(esc_cnt), 0);

    // R2 R3 exhaustive clean sweep
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          run_op(a, b, s[0], 0, 1'b0, 0, "R3 clean");

    // R4 R11 transient on every result bit
    for (int bt = 0; bt <= W; bt++)
      for (int s = 0; s < 2; s++)
        run_op(bt * 3 % 16, 15 - bt, s[0], 1, 1'b0, bt, "R4 transient");

    // R5 alternate path on every bit
    for (int bt = 0; bt <= W; bt++)
      for (int s = 0; s < 2; s++)
        run_op(15 - bt, bt * 2, s[0], 2, 1'b0, bt, "R5 alternate");

    // R6 uncorrectable, followed by R10 clean operation
    for (int bt = 0; bt <= W; bt++) begin
      run_op(bt, 7, bt[0], 2, 1'b1, bt, "R6 uncorrectable");
      run_op(9, bt, 1'b0, 0, 1'b0, 0, "R10 clean after fault");
    end

    @(negedge clk);
    chk(int'(esc_cnt) == exp_esc, "R8 esc_cnt", int'(esc_cnt), exp_esc);
    chk(int'(trans_cnt) == exp_trans, "R7 trans_cnt", int'(trans_cnt), exp_trans);

    // R7 saturation
    for (int i = 0; i < 250; i++)
      run_op(i % 16, (i * 7) % 16, i[0], 1, 1'b0, i % (W + 1), "R7 sat run");
    @(negedge clk);
    chk(int'(trans_cnt) == 255, "R7 trans_cnt saturated", int'(trans_cnt), 255);
    chk(int'(esc_cnt) == exp_esc, "R8 esc_cnt unchanged", int'(esc_cnt), exp_esc);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule